// File: doc/BRIEF.md
# I2C SCL Two-Stage Clock Divider

This block derives the serial clock timing of an I2C master from a fast system clock. Two programmable prescalers are chained. The first is 2 bits wide and scales by 1 to 4. The second is 6 bits wide and scales by 1 to 64. Together they produce a one-cycle `tick` every (A+1)×(B+1) system clocks. A bit phase counter advances on each tick, and one SCL bit lasts a fixed 22 ticks. The SCL frequency is therefore the system clock divided by 22×(A+1)×(B+1). Because (A+1)×(B+1) is at most 256, a 100 MHz clock reaches down to about 17.8 kHz. A 400 kHz bus needs a product of about 11 or more at 100 MHz.

The byte sequencer that drives SDA uses the outputs of this block. `scl_out` is the level SCL should take, where 1 means released. `mid_low` marks the middle of the low half, the moment to change SDA. `mid_high` marks the middle of the high half, the moment to sample SDA. The divider fields come from the control register: A sits at control bits 15:14 and B at control bits 13:8. When the register drives either field to a new value, the counters restart from a clean phase. When `enable` is low, the block is idle and SCL is released.

Top module: `scl_divider`

## Requirements
- R1: While enabled with fields A and B unchanged, `tick` pulses for exactly one clock every N=(A+1)×(B+1) clocks. The first pulse is visible after the N-th rising edge at which `enable` is sampled high (when N=1, `tick` stays high continuously).
- R2: `div_a` is a 2-bit factor (1..4) and `div_b` is a 6-bit factor (1..64). Every combination is valid, including the largest, N=256.
- R3: While `enable` stays high and the fields are stable, `scl_out` changes only in a cycle where `tick` is high.
- R4: A bit lasts 22 ticks. Counting from enable, `scl_out` is 0 for ticks 0..10 and 1 for ticks 11..21. It rises after 11×N clocks and falls again after 22×N clocks.
- R5: `mid_low` pulses with the 5th tick of each bit (after 5×N clocks), while `scl_out` is 0.
- R6: `mid_high` pulses with the 16th tick of each bit (after 16×N clocks), while `scl_out` is 1.
- R7: A change of `div_a` or `div_b` clears both prescalers and the bit phase at the next edge. The next `tick` then follows N_new clocks later, so N_new+1 edges after the change is applied.
- R8: While `enable` is low, `scl_out` is 1, no `tick` or strobe is issued, and the counters are held at zero. After re-enabling, the first tick again comes after N clocks.
- R9: After reset, `scl_out` is 1 and `tick`, `mid_low` and `mid_high` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the divider; low holds it idle |
| div_a | input | 2 | First-stage factor minus one (control bits 15:14) |
| div_b | input | 6 | Second-stage factor minus one (control bits 13:8) |
| tick | output | 1 | One-cycle bit-phase tick |
| scl_out | output | 1 | SCL level, 1 = released |
| mid_low | output | 1 | Middle of SCL low half, change SDA |
| mid_high | output | 1 | Middle of SCL high half, sample SDA |

## Verification
A prescaler that miscounts shows up in the very first tick: the gap from enable to `tick` differs from N within at most 256 clocks. A wrong bit phase moves the SCL edges and the strobes by whole multiples of N. This becomes visible within one bit time, at most 5632 clocks. A reload that fails to clear stale counter state shows up as a first tick after a field change that arrives earlier or later than N_new+1 edges. A disable that fails to clear state shows up the same way after re-enable.

// File: rtl/scl_divider.sv
module scl_divider #(
  parameter int A_W       = 2,
  parameter int B_W       = 6,
  parameter int BIT_TICKS = 22
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic [A_W-1:0] div_a,
  input  logic [B_W-1:0] div_b,
  output logic           tick,
  output logic           scl_out,
  output logic           mid_low,
  output logic           mid_high
);
  localparam int PW       = $clog2(BIT_TICKS);
  localparam int HALF     = BIT_TICKS / 2;
  localparam int MID_LO   = HALF / 2;
  localparam int MID_HI   = HALF + MID_LO;
  localparam logic [PW-1:0] LAST  = PW'(BIT_TICKS - 1);

  logic [A_W-1:0] cnt_a, a_q;
  logic [B_W-1:0] cnt_b, b_q;
  logic [PW-1:0]  phase;
  logic           tick_q;

  wire reload = (div_a != a_q) || (div_b != b_q);
  wire a_wrap = cnt_a == div_a;
  wire b_wrap = cnt_b == div_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= div_a;
      b_q <= div_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_a  <= '0;
      cnt_b  <= '0;
      phase  <= '0;
      tick_q <= 1'b0;
    end else if (!enable || reload) begin
      cnt_a  <= '0;
      cnt_b  <= '0;
      phase  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= a_wrap && b_wrap;
      if (a_wrap) begin
        cnt_a <= '0;
        if (b_wrap) begin
          cnt_b <= '0;
          phase <= (phase == LAST) ? '0 : phase + 1'b1;
        end else begin
          cnt_b <= cnt_b + 1'b1;
        end
      end else begin
        cnt_a <= cnt_a + 1'b1;
      end
    end
  end

  assign tick     = tick_q;
  assign scl_out  = !enable || (phase >= PW'(HALF));
  assign mid_low  = tick_q && (phase == PW'(MID_LO));
  assign mid_high = tick_q && (phase == PW'(MID_HI));
endmodule

// File: rtl/scl_divider_checker.sv
module scl_divider_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [1:0] div_a,
  input logic [5:0] div_b,
  input logic       tick,
  input logic       scl_out,
  input logic       mid_low,
  input logic       mid_high
);
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div_a != 2'd0 || div_b != 6'd0)) |=> !tick);

  a_r3_scl_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && $stable(div_a) && $stable(div_b) &&
     $past(div_a) == $past(div_a, 2) && $past(div_b) == $past(div_b, 2) &&
     scl_out != $past(scl_out)) |-> tick);

  a_r5_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
    mid_low |-> (!scl_out && !mid_high));

  a_r6_sample_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    mid_high |-> scl_out);

  a_r7_reload_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (div_a != $past(div_a) || div_b != $past(div_b))) |=> !tick);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!tick && !mid_low && !mid_high));
endmodule

bind scl_divider scl_divider_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .div_a(div_a), .div_b(div_b),
  .tick(tick), .scl_out(scl_out), .mid_low(mid_low), .mid_high(mid_high)
);

// File: tb/scl_divider_test.sv
module scl_divider_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] div_a = '0;
  logic [5:0] div_b = '0;
  logic tick, scl_out, mid_low, mid_high;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_divider uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_a(div_a), .div_b(div_b),
    .tick(tick), .scl_out(scl_out), .mid_low(mid_low), .mid_high(mid_high)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic setup(int a, int b);
    @(negedge clk);
    enable = 1'b0;
    div_a = 2'(a);
    div_b = 6'(b);
    repeat (3) @(negedge clk);
  endtask

  task automatic edges_to_tick(output int k);
    k = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      k++;
      if (tick) break;
    end
  endtask

  task automatic t_reset();
    check("R9 scl", int'(scl_out), 1);
    check("R9 tick", int'(tick), 0);
    check("R9 strobes", int'(mid_low | mid_high), 0);
  endtask

  task automatic t_rate(int a, int b);
    int n, k;
    n = (a + 1) * (b + 1);
    setup(a, b);
    enable = 1'b1;
    edges_to_tick(k);
    check("R1 first tick", k, n);
    if (n > 1) begin
      @(negedge clk);
      check("R1 width", int'(tick), 0);
      edges_to_tick(k);
      check("R2 spacing", k + 1, n);
    end
  endtask

  task automatic t_bit(int a, int b);
    int n, rise, fall, lo_at, hi_at, lo_bad, hi_bad;
    n = (a + 1) * (b + 1);
    rise = -1; fall = -1; lo_at = -1; hi_at = -1; lo_bad = 0; hi_bad = 0;
    setup(a, b);
    enable = 1'b1;
    for (int c = 1; c <= 22 * n; c++) begin
      @(negedge clk);
      if (scl_out && rise < 0) rise = c;
      if (!scl_out && rise >= 0 && fall < 0) fall = c;
      if (mid_low) begin if (lo_at < 0) lo_at = c; if (scl_out) lo_bad++; end
      if (mid_high) begin if (hi_at < 0) hi_at = c; if (!scl_out) hi_bad++; end
    end
    check("R4 rise", rise, 11 * n);
    check("R4 fall", fall, 22 * n);
    check("R5 mid_low", lo_at, 5 * n);
    check("R5 low level", lo_bad, 0);
    check("R6 mid_high", hi_at, 16 * n);
    check("R6 high level", hi_bad, 0);
  endtask

  task automatic t_reload();
    int k;
    setup(0, 9);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    div_a = 2'd1;
    div_b = 6'd1;
    edges_to_tick(k);
    check("R7 reload", k, 5);
  endtask

  task automatic t_disable();
    int k, bad;
    bad = 0;
    setup(1, 3);
    enable = 1'b1;
    repeat (13) @(negedge clk);
    enable = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!scl_out || tick || mid_low || mid_high) bad++;
    end
    check("R8 idle", bad, 0);
    enable = 1'b1;
    edges_to_tick(k);
    check("R8 restart", k, 8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_rate(0, 0);
    t_rate(1, 2);
    t_rate(3, 63);
    t_bit(0, 1);
    t_bit(2, 4);
    t_bit(3, 63);
    t_reload();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule